// File: doc/BRIEF.md
# Byte ALU with Flag Rules

This block is the arithmetic and logic stage of a small accumulator-style core. Each cycle it takes a working-register operand, a second operand (a file register or an immediate, chosen by the core), the current carry and a 4-bit operation code. It returns the registered result together with a zero flag and a carry flag. Each flag has its own write-enable, so the core updates its status register only for operations that are meant to touch it.

Subtraction always computes the second operand minus the working register. This covers both the file form and the literal form, in which the literal is the minuend. After a subtraction the carry is set when no borrow occurred, so a cleared carry means the result went negative. Rotates move bits through the carry. The increment-and-skip and decrement-and-skip forms raise a skip output when the wrapped result is zero, and they leave the zero flag alone.

The result and the flags are registered, so they appear one clock after the operands are presented. The core chooses where the result is written back, and bit set/clear decoding is done outside this block.

Top module: `byte_alu`

## Requirements
- R1: While rst_n is low and after it is released, until the first operation is captured, result_o is 0 and zero_o, zero_we_o, carry_o, carry_we_o and skip_o are all 0.
- R2: All outputs are registered: an operation presented before a rising edge appears on the outputs just after that edge and holds until the next edge.
- R3: Opcode 1 (add) gives result = (wreg_i + opnd_i) mod 256 and asserts carry_we_o. carry_o is 1 exactly when the 9-bit sum exceeds 255.
- R4: Opcode 2 (subtract) gives result = (opnd_i - wreg_i) mod 256 and asserts carry_we_o. carry_o is 1 (no borrow) exactly when opnd_i >= wreg_i.
- R5: Opcodes 3, 4 and 5 give opnd_i AND, OR and XOR wreg_i. Opcode 12 gives the bitwise inverse of opnd_i. All four update zero only.
- R6: Opcode 6 (clear) gives result 0 with zero_we_o = 1, zero_o = 1 and carry_we_o = 0.
- R7: Opcodes 7 and 8 give opnd_i + 1 and opnd_i - 1 modulo 256 (FFh wraps to 00h, 00h wraps to FFh). Both update zero only.
- R8: Opcodes 9 and 10 (increment-and-skip, decrement-and-skip) compute the same results as opcodes 7 and 8 but keep zero_we_o and carry_we_o at 0. skip_o is 1 exactly when the result is 0.
- R9: Opcode 11 (nibble swap) gives {opnd_i[3:0], opnd_i[7:4]} and asserts neither write-enable.
- R10: Opcode 13 rotates left through carry: result = {opnd_i[6:0], carry_i} and carry_o = opnd_i[7]. Opcode 14 rotates right through carry: result = {carry_i, opnd_i[7:1]} and carry_o = opnd_i[0]. Rotates assert carry_we_o only.
- R11: Opcode 0 (move) passes opnd_i through and updates zero but not carry. Reserved opcode 15 also passes opnd_i through, with no write-enable.
- R12: Carry is written only by opcodes 1, 2, 13 and 14. Whenever zero_we_o is 1, zero_o equals (result_o == 0). A flag value output reads 0 whenever its write-enable is 0, and skip_o is 0 for every opcode except 9 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| wreg_i | input | W (8) | Working-register operand |
| opnd_i | input | W (8) | File-register or literal operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | W (8) | Registered result |
| zero_o | output | 1 | New zero flag value |
| zero_we_o | output | 1 | Zero flag write-enable |
| carry_o | output | 1 | New carry flag value |
| carry_we_o | output | 1 | Carry flag write-enable |
| skip_o | output | 1 | Skip request from the skip variants |

## Verification
The hardest cases sit at the edges of the carry chain. One is a subtraction with equal operands, which must report no borrow and a zero result at once. Another is a skip variant that wraps from FFh to 00h, which must raise skip while keeping the zero write-enable low, even though the result is zero. The directed tasks drive these exact operand pairs. They also drive rotates with both values of carry_i, because only the incoming carry separates the two results.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOVE   = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB    = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_CLR    = 4'd6,
    OP_INC    = 4'd7,
    OP_DEC    = 4'd8,
    OP_INCSKP = 4'd9,
    OP_DECSKP = 4'd10,
    OP_SWAP   = 4'd11,
    OP_COM    = 4'd12,
    OP_RLC    = 4'd13,
    OP_RRC    = 4'd14,
    OP_RSVD   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic z_we;
    logic c;
    logic c_we;
    logic skip;
  } alu_flags_t;

  function automatic logic op_writes_carry(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_RLC) || (op == OP_RRC);
  endfunction

  function automatic logic op_writes_zero(alu_op_e op);
    case (op)
      OP_MOVE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
      OP_CLR, OP_INC, OP_DEC, OP_COM: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_skip(alu_op_e op);
    return (op == OP_INCSKP) || (op == OP_DECSKP);
  endfunction

endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           sel
);
  localparam int WX = W + 1;

  function automatic logic [WX-1:0] add_ext(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // minuend y, subtrahend x; top bit is the "no borrow" indication
  function automatic logic [WX-1:0] sub_ext(logic [W-1:0] y, logic [W-1:0] x);
    return {1'b0, y} + {1'b0, ~x} + WX'(1);
  endfunction

  logic [WX-1:0] sum_x;
  logic [WX-1:0] dif_x;
  logic [W-1:0]  inc_v;
  logic [W-1:0]  dec_v;

  assign sum_x = add_ext(a, b);
  assign dif_x = sub_ext(b, a);
  assign inc_v = b + W'(1);
  assign dec_v = b - W'(1);

  always_comb begin
    res  = '0;
    cout = 1'b0;
    sel  = 1'b1;
    case (op)
      OP_ADD:            begin res = sum_x[W-1:0]; cout = sum_x[W]; end
      OP_SUB:            begin res = dif_x[W-1:0]; cout = dif_x[W]; end
      OP_INC, OP_INCSKP: res = inc_v;
      OP_DEC, OP_DECSKP: res = dec_v;
      default:           sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           sel
);
  localparam int HALF = W / 2;

  function automatic logic [W-1:0] swap_halves(logic [W-1:0] x);
    return {x[HALF-1:0], x[W-1:HALF]};
  endfunction

  always_comb begin
    res = '0;
    sel = 1'b1;
    case (op)
      OP_MOVE, OP_RSVD: res = b;
      OP_AND:           res = a & b;
      OP_OR:            res = a | b;
      OP_XOR:           res = a ^ b;
      OP_CLR:           res = '0;
      OP_COM:           res = ~b;
      OP_SWAP:          res = swap_halves(b);
      default:          sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_rot.sv
module byte_alu_rot
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           sel
);
  always_comb begin
    res  = '0;
    cout = 1'b0;
    sel  = 1'b1;
    case (op)
      OP_RLC:  begin res = {b[W-2:0], cin}; cout = b[W-1]; end
      OP_RRC:  begin res = {cin, b[W-1:1]}; cout = b[0];   end
      default: sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   res,
  input  logic           cy,
  output alu_flags_t     flg
);
  logic res_is_zero;
  assign res_is_zero = (res == '0);

  always_comb begin
    flg.z_we = op_writes_zero(op);
    flg.c_we = op_writes_carry(op);
    flg.z    = flg.z_we & res_is_zero;
    flg.c    = flg.c_we & cy;
    flg.skip = op_is_skip(op) & res_is_zero;
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] wreg_i,
  input  logic [W-1:0] opnd_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         zero_we_o,
  output logic         carry_o,
  output logic         carry_we_o,
  output logic         skip_o
);
  alu_op_e    op;
  logic [W-1:0] ar_res, lg_res, rt_res, res_d;
  logic       ar_c, rt_c, cy_d;
  logic       ar_sel, lg_sel, rt_sel;
  alu_flags_t flg_d;
  logic       primed;

  assign op = alu_op_e'(op_i);

  byte_alu_arith #(.W(W)) u_arith (
    .op(op), .a(wreg_i), .b(opnd_i), .res(ar_res), .cout(ar_c), .sel(ar_sel));

  byte_alu_logic #(.W(W)) u_logic (
    .op(op), .a(wreg_i), .b(opnd_i), .res(lg_res), .sel(lg_sel));

  byte_alu_rot #(.W(W)) u_rot (
    .op(op), .b(opnd_i), .cin(carry_i), .res(rt_res), .cout(rt_c), .sel(rt_sel));

  always_comb begin
    res_d = lg_res;
    cy_d  = 1'b0;
    if (ar_sel) begin
      res_d = ar_res;
      cy_d  = ar_c;
    end else if (rt_sel) begin
      res_d = rt_res;
      cy_d  = rt_c;
    end
  end

  byte_alu_flags #(.W(W)) u_flags (
    .op(op), .res(res_d), .cy(cy_d), .flg(flg_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o   <= '0;
      zero_o     <= 1'b0;
      zero_we_o  <= 1'b0;
      carry_o    <= 1'b0;
      carry_we_o <= 1'b0;
      skip_o     <= 1'b0;
      primed     <= 1'b0;
    end else begin
      result_o   <= res_d;
      zero_o     <= flg_d.z;
      zero_we_o  <= flg_d.z_we;
      carry_o    <= flg_d.c;
      carry_we_o <= flg_d.c_we;
      skip_o     <= flg_d.skip;
      primed     <= 1'b1;
    end
  end

  // exactly one unit claims each opcode
  always_comb begin
    if (rst_n) begin
      unit_claim_chk: assert ($countones({ar_sel, lg_sel, rt_sel}) == 1);
    end
  end

  // R12
  carry_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !($past(op_i) inside {4'd1, 4'd2, 4'd13, 4'd14})) |-> !carry_we_o);

  // R12
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_we_o |-> (zero_o == (result_o == '0)));

  // R4
  no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_i) == 4'd2) |-> (carry_we_o && carry_o == ($past(opnd_i) >= $past(wreg_i))));

  // R8
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (result_o == '0 && !zero_we_o && !carry_we_o));

  // R10
  rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_i) == 4'd13) |-> (carry_o == $past(opnd_i[W-1]) && result_o[0] == $past(carry_i)));

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_i) == 4'd1) |-> ({carry_o, result_o} == ({1'b0, $past(wreg_i)} + {1'b0, $past(opnd_i)})));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !primed |-> (result_o == '0 && !zero_we_o && !carry_we_o && !skip_o));
endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] wreg_i = 8'd0;
  logic [7:0] opnd_i = 8'd0;
  logic       carry_i = 1'b0;
  logic [7:0] result_o;
  logic       zero_o, zero_we_o, carry_o, carry_we_o, skip_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .wreg_i(wreg_i), .opnd_i(opnd_i),
    .carry_i(carry_i), .result_o(result_o), .zero_o(zero_o), .zero_we_o(zero_we_o),
    .carry_o(carry_o), .carry_we_o(carry_we_o), .skip_o(skip_o));

  task automatic compare(string req, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got res=%h z=%b zwe=%b c=%b cwe=%b sk=%b expected res=%h z=%b zwe=%b c=%b cwe=%b sk=%b",
               req, act[12:5], act[4], act[3], act[2], act[1], act[0],
               exp[12:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // independent reference built from the requirement text
  function automatic logic [12:0] model(int op, int a, int b, int ci);
    int r; int c; int zw; int cw; int sk;
    r = b; c = 0; zw = 0; cw = 0; sk = 0;
    case (op)
      0:  begin r = b; zw = 1; end
      1:  begin r = (a + b) % 256; c = (a + b > 255); cw = 1; zw = 1; end
      2:  begin r = (b - a + 256) % 256; c = (b >= a); cw = 1; zw = 1; end
      3:  begin r = a & b; zw = 1; end
      4:  begin r = a | b; zw = 1; end
      5:  begin r = a ^ b; zw = 1; end
      6:  begin r = 0; zw = 1; end
      7:  begin r = (b + 1) % 256; zw = 1; end
      8:  begin r = (b + 255) % 256; zw = 1; end
      9:  begin r = (b + 1) % 256; sk = (r == 0); end
      10: begin r = (b + 255) % 256; sk = (r == 0); end
      11: begin r = ((b % 16) * 16) + (b / 16); end
      12: begin r = 255 - b; zw = 1; end
      13: begin r = ((b * 2) % 256) + ci; c = b / 128; cw = 1; end
      14: begin r = ci * 128 + b / 2; c = b % 2; cw = 1; end
      default: r = b;
    endcase
    return {8'(r), (zw != 0) && (r == 0), 1'(zw), (cw != 0) && (c != 0), 1'(cw), 1'(sk)};
  endfunction

  task automatic run(string req, int op, int a, int b, int ci);
    @(negedge clk);
    op_i = 4'(op); wreg_i = 8'(a); opnd_i = 8'(b); carry_i = 1'(ci);
    @(posedge clk); #1;
    compare(req, {result_o, zero_o, zero_we_o, carry_o, carry_we_o, skip_o}, model(op, a, b, ci));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_i = 4'd1; wreg_i = 8'hFF; opnd_i = 8'hFF; carry_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1", {result_o, zero_o, zero_we_o, carry_o, carry_we_o, skip_o}, 13'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency;
    // R2: result appears after one edge and holds until the next one
    @(negedge clk);
    op_i = 4'd1; wreg_i = 8'h12; opnd_i = 8'h34;
    @(posedge clk); #1;
    op_i = 4'd6;
    #1 compare("R2", {result_o, zero_o, zero_we_o, carry_o, carry_we_o, skip_o}, model(1, 8'h12, 8'h34, 0));
  endtask

  task automatic t_add;
    run("R3", 1, 8'h12, 8'h34, 0);
    run("R3", 1, 8'hFF, 8'hFF, 1);
    run("R3", 1, 8'h80, 8'h80, 0);
    run("R3", 1, 8'h01, 8'hFE, 0);
  endtask

  task automatic t_sub;
    run("R4", 2, 8'h03, 8'h05, 0);
    run("R4", 2, 8'h05, 8'h03, 1);
    run("R4", 2, 8'h42, 8'h42, 0);
    run("R4", 2, 8'h00, 8'h00, 0);
    run("R4", 2, 8'hFF, 8'h00, 1);
  endtask

  task automatic t_logic;
    run("R5", 3, 8'h0F, 8'h55, 1);
    run("R5", 3, 8'hF0, 8'h0F, 0);
    run("R5", 4, 8'hA0, 8'h05, 1);
    run("R5", 5, 8'h3C, 8'h3C, 1);
    run("R5", 12, 8'h00, 8'hFF, 1);
    run("R5", 12, 8'h00, 8'h5A, 0);
  endtask

  task automatic t_clear;
    run("R6", 6, 8'hAB, 8'hCD, 1);
  endtask

  task automatic t_incdec;
    run("R7", 7, 8'h00, 8'hFF, 1);
    run("R7", 7, 8'h00, 8'h41, 0);
    run("R7", 8, 8'h00, 8'h01, 1);
    run("R7", 8, 8'h00, 8'h00, 0);
  endtask

  task automatic t_skip;
    run("R8", 9, 8'h00, 8'hFF, 1);
    run("R8", 9, 8'h00, 8'h10, 0);
    run("R8", 10, 8'h00, 8'h01, 0);
    run("R8", 10, 8'h00, 8'h00, 1);
  endtask

  task automatic t_swap;
    run("R9", 11, 8'h00, 8'hA5, 1);
    run("R9", 11, 8'h00, 8'h00, 0);
  endtask

  task automatic t_rotate;
    run("R10", 13, 8'h00, 8'h81, 0);
    run("R10", 13, 8'h00, 8'h40, 1);
    run("R10", 14, 8'h00, 8'h01, 0);
    run("R10", 14, 8'h00, 8'h80, 1);
  endtask

  task automatic t_move;
    run("R11", 0, 8'h77, 8'h00, 1);
    run("R11", 0, 8'h00, 8'h9C, 1);
    run("R11", 15, 8'h11, 8'h00, 1);
  endtask

  task automatic t_flag_rules;
    // R12: sweep every opcode with one operand pair
    for (int k = 0; k < 16; k++) run("R12", k, 8'hC3, 8'hC3, 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_logic();
    t_clear();
    t_incdec();
    t_skip();
    t_swap();
    t_rotate();
    t_move();
    t_flag_rules();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule